// File: doc/BRIEF.md
# Payload Data Row Decoder

This block sits behind a packet framer that has already checked the sync bytes and the checksum. It takes the payload of one good packet as a byte stream. A start marker goes with the first payload byte and an end marker goes with the last one. The decoder splits the payload into rows. Each row is one code byte followed by a data field, and the length of that field is fixed by the code.

A one-byte value is presented on a parallel bus together with its code. A multi-byte value is forwarded byte by byte with first and last markers. The two-byte raw sample is also assembled into a signed 16-bit word.

Three conditions raise a one-cycle error strobe: a code missing from the table, the extended-code escape, and a row that reaches the end of the payload. After an unknown code or an escape, the rest of the payload is swallowed without output.

Every output is registered and appears on the clock edge after the edge that accepts the input byte.

Top module: `rowDecoder`

## Requirements
- R1: While reset is held and right after it, every strobe output is low and `rowCode` and `rawSample` read zero.
- R2: Codes 0x02, 0x04, 0x05 and 0x16 carry one data byte. One cycle after that byte is accepted, `scalarValid` pulses for one cycle with `scalarData` equal to the byte and `rowCode` equal to the code.
- R3: Code 0x80 carries 2 data bytes and code 0x83 carries 24. Each data byte is forwarded on `streamData` with `streamValid`, one cycle after it is accepted. `streamFirst` marks the first data byte and `streamLast` marks the final one, and `rowCode` holds the code.
- R4: For code 0x80, `rawValid` pulses in the same cycle as `streamLast`. `rawSample` then equals the first data byte as the high half and the second as the low half, read as a signed value.
- R5: Code 0x55 in a code position raises `errExtended` for one cycle. Every following byte up to the end marker produces no output.
- R6: A code byte that is none of 0x02, 0x04, 0x05, 0x16, 0x55, 0x80 and 0x83 raises `errUnknown` for one cycle. Every following byte up to the end marker produces no output.
- R7: `errTruncated` pulses and the byte produces no data output in either of two cases: the end marker comes with a known code byte, or it comes with any data byte, including the final data byte of a row.
- R8: The byte after the final data byte of a row is taken as the next code, so one payload can carry several rows back to back.
- R9: The byte with the start marker is always taken as a code, even if the previous payload stopped inside a row. After any end marker the next byte is taken as a code.
- R10: At most one of `scalarValid`, `streamValid`, `errUnknown`, `errExtended` and `errTruncated` is high in a cycle. Scalar output only carries codes below 0x80, and stream output only carries codes at or above 0x80.
- R11: A cycle with `inValid` low changes no state and produces no strobe in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | `inByte` carries a payload byte this cycle |
| inFirst | input | 1 | Byte is the first of a payload |
| inLast | input | 1 | Byte is the last of a payload |
| inByte | input | 8 | Payload byte |
| rowCode | output | 8 | Code of the current row |
| scalarValid | output | 1 | One-byte value present |
| scalarData | output | 8 | One-byte value |
| streamValid | output | 1 | Multi-byte data byte present |
| streamData | output | 8 | Multi-byte data byte |
| streamFirst | output | 1 | First byte of a multi-byte field |
| streamLast | output | 1 | Final byte of a multi-byte field |
| rawValid | output | 1 | Raw sample complete |
| rawSample | output | 16 | Signed raw sample, high byte first |
| errUnknown | output | 1 | Code not in the table |
| errExtended | output | 1 | Extended-code escape seen |
| errTruncated | output | 1 | Row reached the payload end and was dropped |

## Verification
Completing a raw sample and ending its byte stream are two separate decisions, and both land on the same output cycle. The bench feeds a full 0x80 row and requires `rawValid`, `streamLast` and the second byte on `streamData` all together, with `rawSample` built from both bytes. The opposite collision, an end marker arriving with the final data byte, is driven for both the two-byte and the 24-byte fields. In that case the only acceptable result is `errTruncated` with no stream or raw strobe.

// File: rtl/rowDecPkg.sv
package rowDecPkg;
  localparam int BYTE_W = 8;
  localparam int RAW_W  = 2 * BYTE_W;
  localparam int MAX_LEN = 24;
  localparam int LEN_W  = $clog2(MAX_LEN + 1);

  localparam logic [BYTE_W-1:0] CODE_EXT = 8'h55;
  localparam logic [BYTE_W-1:0] CODE_RAW = 8'h80;

  // Strobes from control to datapath, one decision per accepted byte.
  typedef struct packed {
    logic loadCode;
    logic scalarOut;
    logic streamOut;
    logic streamFirst;
    logic streamLast;
    logic rawHi;
    logic rawOut;
    logic errUnknown;
    logic errExtended;
    logic errTruncated;
  } ctrlStrobes_t;

  // Data field length per code, zero for codes outside the table.
  function automatic logic [LEN_W-1:0] rowLength(input logic [BYTE_W-1:0] code);
    case (code)
      8'h02, 8'h04, 8'h05, 8'h16: return LEN_W'(1);
      8'h80:                      return LEN_W'(2);
      8'h83:                      return LEN_W'(MAX_LEN);
      default:                    return '0;
    endcase
  endfunction
endpackage

// File: rtl/rowDecCtrl.sv
module rowDecCtrl
  import rowDecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic [BYTE_W-1:0] inByte,
  input  logic [BYTE_W-1:0] curCode,
  output ctrlStrobes_t      strobes
);
  typedef enum logic [1:0] {ST_CODE, ST_DATA, ST_SKIP} state_t;

  state_t           state, stateNext;
  logic [LEN_W-1:0] remain, remainNext;
  logic             firstByte, firstNext;
  logic [LEN_W-1:0] len;
  logic             atCode;

  assign len    = rowLength(inByte);
  assign atCode = inFirst || (state == ST_CODE);

  always_comb begin
    strobes    = '0;
    stateNext  = state;
    remainNext = remain;
    firstNext  = firstByte;
    if (inValid) begin
      if (atCode) begin
        if (inByte == CODE_EXT) begin
          strobes.errExtended = 1'b1;
          stateNext = inLast ? ST_CODE : ST_SKIP;
        end else if (len == '0) begin
          strobes.errUnknown = 1'b1;
          stateNext = inLast ? ST_CODE : ST_SKIP;
        end else if (inLast) begin
          strobes.errTruncated = 1'b1;
          stateNext = ST_CODE;
        end else begin
          strobes.loadCode = 1'b1;
          remainNext = len;
          firstNext  = 1'b1;
          stateNext  = ST_DATA;
        end
      end else if (state == ST_DATA) begin
        if (inLast) begin
          strobes.errTruncated = 1'b1;
          stateNext = ST_CODE;
        end else begin
          if (!curCode[BYTE_W-1]) begin
            strobes.scalarOut = 1'b1;
          end else begin
            strobes.streamOut   = 1'b1;
            strobes.streamFirst = firstByte;
            strobes.streamLast  = (remain == LEN_W'(1));
            if (curCode == CODE_RAW) begin
              strobes.rawHi  = firstByte;
              strobes.rawOut = (remain == LEN_W'(1));
            end
          end
          firstNext  = 1'b0;
          remainNext = remain - LEN_W'(1);
          if (remain == LEN_W'(1)) stateNext = ST_CODE;
        end
      end else if (inLast) begin
        stateNext = ST_CODE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_CODE;
      remain    <= '0;
      firstByte <= 1'b0;
    end else begin
      state     <= stateNext;
      remain    <= remainNext;
      firstByte <= firstNext;
    end
  end
endmodule

// File: rtl/rowDecData.sv
module rowDecData
  import rowDecPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [BYTE_W-1:0]       inByte,
  input  ctrlStrobes_t            strobes,
  output logic [BYTE_W-1:0]       rowCode,
  output logic                    scalarValid,
  output logic [BYTE_W-1:0]       scalarData,
  output logic                    streamValid,
  output logic [BYTE_W-1:0]       streamData,
  output logic                    streamFirst,
  output logic                    streamLast,
  output logic                    rawValid,
  output logic signed [RAW_W-1:0] rawSample,
  output logic                    errUnknown,
  output logic                    errExtended,
  output logic                    errTruncated
);
  logic [BYTE_W-1:0] rawHiReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowCode      <= '0;
      scalarValid  <= 1'b0;
      scalarData   <= '0;
      streamValid  <= 1'b0;
      streamData   <= '0;
      streamFirst  <= 1'b0;
      streamLast   <= 1'b0;
      rawValid     <= 1'b0;
      rawSample    <= '0;
      rawHiReg     <= '0;
      errUnknown   <= 1'b0;
      errExtended  <= 1'b0;
      errTruncated <= 1'b0;
    end else begin
      scalarValid  <= strobes.scalarOut;
      streamValid  <= strobes.streamOut;
      streamFirst  <= strobes.streamFirst;
      streamLast   <= strobes.streamLast;
      rawValid     <= strobes.rawOut;
      errUnknown   <= strobes.errUnknown;
      errExtended  <= strobes.errExtended;
      errTruncated <= strobes.errTruncated;
      if (strobes.loadCode)  rowCode    <= inByte;
      if (strobes.scalarOut) scalarData <= inByte;
      if (strobes.streamOut) streamData <= inByte;
      if (strobes.rawHi)     rawHiReg   <= inByte;
      if (strobes.rawOut)    rawSample  <= {rawHiReg, inByte};
    end
  end
endmodule

// File: rtl/rowDecoder.sv
module rowDecoder
  import rowDecPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic [7:0]        inByte,
  output logic [7:0]        rowCode,
  output logic              scalarValid,
  output logic [7:0]        scalarData,
  output logic              streamValid,
  output logic [7:0]        streamData,
  output logic              streamFirst,
  output logic              streamLast,
  output logic              rawValid,
  output logic signed [15:0] rawSample,
  output logic              errUnknown,
  output logic              errExtended,
  output logic              errTruncated
);
  ctrlStrobes_t strobes;

  rowDecCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inFirst (inFirst),
    .inLast  (inLast),
    .inByte  (inByte),
    .curCode (rowCode),
    .strobes (strobes)
  );

  rowDecData u_data (
    .clk          (clk),
    .rstN         (rstN),
    .inByte       (inByte),
    .strobes      (strobes),
    .rowCode      (rowCode),
    .scalarValid  (scalarValid),
    .scalarData   (scalarData),
    .streamValid  (streamValid),
    .streamData   (streamData),
    .streamFirst  (streamFirst),
    .streamLast   (streamLast),
    .rawValid     (rawValid),
    .rawSample    (rawSample),
    .errUnknown   (errUnknown),
    .errExtended  (errExtended),
    .errTruncated (errTruncated)
  );
endmodule

// File: rtl/rowDecChecker.sv
module rowDecChecker (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inFirst,
  input logic              inLast,
  input logic [7:0]        inByte,
  input logic [7:0]        rowCode,
  input logic              scalarValid,
  input logic [7:0]        scalarData,
  input logic              streamValid,
  input logic [7:0]        streamData,
  input logic              streamFirst,
  input logic              streamLast,
  input logic              rawValid,
  input logic signed [15:0] rawSample,
  input logic              errUnknown,
  input logic              errExtended,
  input logic              errTruncated
);
  p_one_event_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({scalarValid, streamValid, errUnknown, errExtended, errTruncated}));

  p_scalar_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    scalarValid |-> !rowCode[7]);

  p_stream_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    streamValid |-> rowCode[7]);

  p_markers_r3: assert property (@(posedge clk) disable iff (!rstN)
    (streamFirst || streamLast) |-> streamValid);

  p_raw_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    rawValid |-> (streamValid && streamLast && rowCode == 8'h80 && rawSample[7:0] == streamData));

  p_end_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inLast) |=> (!scalarValid && !streamValid && !rawValid));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !(scalarValid || streamValid || errUnknown || errExtended || errTruncated));
endmodule

bind rowDecoder rowDecChecker u_chk (.*);

// File: tb/tb_rowDecoder.sv
module tb_rowDecoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inFirst = 1'b0, inLast = 1'b0;
  logic [7:0] inByte = '0;
  logic [7:0] rowCode, scalarData, streamData;
  logic scalarValid, streamValid, streamFirst, streamLast, rawValid;
  logic signed [15:0] rawSample;
  logic errUnknown, errExtended, errTruncated;

  int checkCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rowDecoder dut (.*);

  // Vector: {valid, first, last, byte, expected flags, expected data, expected code}
  // flags: [7]scalar [6]stream [5]first [4]last [3]raw [2]unknown [1]extended [0]truncated
  localparam int NV = 32;
  localparam logic [34:0] VEC [NV] = '{
    {3'b110, 8'h02, 8'h00, 8'h00, 8'h00},
    {3'b100, 8'h33, 8'h80, 8'h33, 8'h02},  // R2
    {3'b000, 8'hAA, 8'h00, 8'h00, 8'h00},  // R11 idle mid-row
    {3'b100, 8'h80, 8'h00, 8'h00, 8'h00},  // R8 next code
    {3'b100, 8'hFF, 8'h60, 8'hFF, 8'h80},
    {3'b000, 8'h00, 8'h00, 8'h00, 8'h00},
    {3'b100, 8'h38, 8'h58, 8'h38, 8'h80},  // R4 raw -200
    {3'b100, 8'h04, 8'h00, 8'h00, 8'h00},
    {3'b100, 8'h55, 8'h80, 8'h55, 8'h04},  // 0x55 as data is plain data
    {3'b100, 8'h16, 8'h00, 8'h00, 8'h00},
    {3'b101, 8'h01, 8'h01, 8'h00, 8'h00},  // R7 final data byte at end
    {3'b110, 8'h55, 8'h02, 8'h00, 8'h00},  // R5
    {3'b100, 8'h02, 8'h00, 8'h00, 8'h00},
    {3'b101, 8'h07, 8'h00, 8'h00, 8'h00},
    {3'b110, 8'hAA, 8'h04, 8'h00, 8'h00},  // R6
    {3'b101, 8'h02, 8'h00, 8'h00, 8'h00},
    {3'b111, 8'h05, 8'h01, 8'h00, 8'h00},  // R7 code at end
    {3'b110, 8'h05, 8'h00, 8'h00, 8'h00},
    {3'b100, 8'h7F, 8'h80, 8'h7F, 8'h05},
    {3'b100, 8'h03, 8'h04, 8'h00, 8'h00},
    {3'b100, 8'h02, 8'h00, 8'h00, 8'h00},  // skipped
    {3'b100, 8'h33, 8'h00, 8'h00, 8'h00},  // skipped
    {3'b101, 8'h00, 8'h00, 8'h00, 8'h00},
    {3'b110, 8'h80, 8'h00, 8'h00, 8'h00},
    {3'b100, 8'h12, 8'h60, 8'h12, 8'h80},
    {3'b101, 8'h34, 8'h01, 8'h00, 8'h00},  // R7 raw cut
    {3'b110, 8'h83, 8'h00, 8'h00, 8'h00},
    {3'b100, 8'h01, 8'h60, 8'h01, 8'h83},
    {3'b110, 8'h02, 8'h00, 8'h00, 8'h00},  // R9 start marker mid-row
    {3'b100, 8'h44, 8'h80, 8'h44, 8'h02},  // R10 scalar only
    {3'b101, 8'h00, 8'h04, 8'h00, 8'h00},
    {3'b000, 8'h00, 8'h00, 8'h00, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] flags();
    return {scalarValid, streamValid, streamFirst, streamLast, rawValid,
            errUnknown, errExtended, errTruncated};
  endfunction

  task automatic drive(input bit v, input bit f, input bit l, input logic [7:0] b);
    inValid = v; inFirst = f; inLast = l; inByte = b;
  endtask

  task automatic push(input bit f, input bit l, input logic [7:0] b);
    @(negedge clk);
    drive(1'b1, f, l, b);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] hiByte;
    bit sawLast;
    hiByte = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(flags() == 8'h00, "R1 strobes in reset", {24'h0, flags()}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(flags() == 8'h00 && rowCode == 8'h00, "R1 after reset", {16'h0, flags(), rowCode}, 0);
    chk(rawSample == 16'sd0, "R1 raw zero", {16'h0, rawSample}, 0);

    // Table walk, back to back bytes
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) begin
        logic [34:0] e;
        string req;
        e = VEC[i-1];
        if (e[16]) req = "R7";
        else if (e[17]) req = "R5";
        else if (e[18]) req = "R6";
        else if (e[19]) req = "R4";
        else if (e[22]) req = "R3";
        else if (e[23]) req = "R2";
        else req = "R8/R11 quiet";
        chk(flags() == e[23:16], req, {24'h0, flags()}, {24'h0, e[23:16]});
        if (e[23]) begin
          chk(scalarData == e[15:8], "R2 data", {24'h0, scalarData}, {24'h0, e[15:8]});
          chk(rowCode == e[7:0], "R2 code", {24'h0, rowCode}, {24'h0, e[7:0]});
        end
        if (e[22]) begin
          chk(streamData == e[15:8], "R3 data", {24'h0, streamData}, {24'h0, e[15:8]});
          chk(rowCode == e[7:0], "R3 code", {24'h0, rowCode}, {24'h0, e[7:0]});
          if (e[21]) hiByte = e[15:8];
        end
        if (e[19])
          chk(rawSample == {hiByte, e[15:8]}, "R4 sample", {16'h0, rawSample}, {16'h0, hiByte, e[15:8]});
      end
      if (i < NV) drive(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:24]);
      else drive(1'b0, 1'b0, 1'b0, 8'h00);
    end

    // R3: full 24-byte field, then R8 next row in same payload
    push(1'b1, 1'b0, 8'h83);
    for (int k = 0; k < 24; k++) begin
      push(1'b0, 1'b0, 8'(8'h20 + k));
      chk(streamValid && streamData == 8'(8'h20 + k) && rowCode == 8'h83, "R3 long byte",
          {23'h0, streamValid, streamData}, {23'h1, 8'(8'h20 + k)});
      chk(streamFirst == (k == 0) && streamLast == (k == 23) && !rawValid, "R3 long markers",
          {29'h0, streamFirst, streamLast, rawValid}, {29'h0, k == 0, k == 23, 1'b0});
    end
    push(1'b0, 1'b0, 8'h04);
    push(1'b0, 1'b0, 8'h66);
    chk(scalarValid && scalarData == 8'h66 && rowCode == 8'h04, "R8 row after long field",
        {15'h0, scalarValid, scalarData, rowCode}, {15'h1, 8'h66, 8'h04});
    push(1'b0, 1'b1, 8'h00);
    chk(errUnknown, "R6 code at end", {31'h0, errUnknown}, 1);

    // R7: 24-byte field cut on its final byte
    sawLast = 1'b0;
    push(1'b1, 1'b0, 8'h83);
    for (int k = 0; k < 23; k++) begin
      push(1'b0, 1'b0, 8'(k));
      if (streamLast) sawLast = 1'b1;
    end
    push(1'b0, 1'b1, 8'hEE);
    chk(errTruncated && !streamValid && !sawLast, "R7 long field cut",
        {29'h0, errTruncated, streamValid, sawLast}, {29'h0, 3'b100});

    // R9: after end marker, next byte without start marker is a code
    push(1'b0, 1'b0, 8'h16);
    push(1'b0, 1'b0, 8'h09);
    chk(scalarValid && scalarData == 8'h09 && rowCode == 8'h16, "R9 code after end",
        {15'h0, scalarValid, scalarData, rowCode}, {15'h1, 8'h09, 8'h16});

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule